// File: doc/BRIEF.md
# Edge-Triggered Priority Interrupt Controller

This block gathers sixteen interrupt lines and one bypass line, spots each 0-to-1 transition on them, and hands qualified interrupts to the processor side as a stream of 6-bit codes. Every source owns a 3-bit priority level. A source interrupt is passed on only when its level exceeds a programmable threshold. The bypass line is always passed on. A small register bus with byte lanes lets software read and change the pending-status word, the threshold and the level words.

The status word is active-low. A detected edge on source s drops bit s to 0. Software acknowledges by writing ones back. Qualified interrupts wait in a pending set and leave through a valid/ready output port. When `irq_valid` is high and `irq_ready` is low, the code is held unchanged. An entry is consumed on a clock edge where both are high. Back-pressure never loses an edge: an edge that arrives while its source is already waiting merges with the waiting entry. A source whose code is already on the port is not waiting, so a new edge for it queues a fresh entry. A synchronous `soft_rst` puts the registers back to their defaults and discards all queued interrupts.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After `rst`, the status word reads 0x0000FFFF, the threshold and all four level words read 0, and `irq_valid` is low.
- R2: `bus_addr` is the byte offset divided by 4. Slot 0 (offset 0x00) is status, slot 1 (0x04) is the threshold, and slots 4..7 (0x10..0x1C) are level words for sources 0-3, 4-7, 8-11 and 12-15. Slots 2 and 3 read 0, and writes to them are dropped.
- R3: A write changes only the byte lanes whose `bus_be` bit is set. Lane b is bits [8b+7:8b].
- R4: A 0-to-1 change of `src_i[s]` between two consecutive clock samples clears status bit s on that edge. A line held high produces no further events.
- R5: The level of source s is bits [(s%4)*8+2 : (s%4)*8] of level slot 4+s/4. The edge is queued only if level > threshold, an unsigned 32-bit compare that uses the register values from before any write made in the same cycle.
- R6: A queued source leaves with code 16+s. A rising edge on `byp_i` leaves with code 32, whatever the levels, and does not touch the status word.
- R7: Once `irq_valid` is high, it and `irq_code` stay stable until a cycle where `irq_ready` is high. That cycle consumes the entry.
- R8: The next code presented is the bypass if it is queued, otherwise the lowest-index queued source. A queued interrupt appears on the port at the second clock edge after the input rose, provided the port is free.
- R9: When a status write and an edge on source s occur in the same cycle, bit s ends at 0 and the other bits take the written lanes.
- R10: `soft_rst` restores the R1 register values, empties the queue and the port, and ignores edges sampled in that cycle.
- R11: Repeated edges on a source that is queued but not yet presented produce a single output entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| soft_rst | input | 1 | Synchronous register and queue restore |
| src_i | input | 16 | Interrupt source lines, index 0..15 |
| byp_i | input | 1 | Bypass interrupt line |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register slot (byte offset / 4) |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed slot |
| irq_valid | output | 1 | Interrupt code available |
| irq_ready | input | 1 | Consumer accepts the code |
| irq_code | output | 6 | Interrupt code (16..31 source, 32 bypass) |

## Verification
Two pairs of functions can land in the same cycle. The first is a software write to the status word together with a hardware edge clearing a bit of it. The bench drives both on one edge and expects the edge's bit to stay 0 while the other written lanes take effect. The second is several source edges and a bypass edge arriving together while the consumer stalls. The bench judges the release order (bypass, then ascending index) and the stability of the held code against a behavioural reference model that is compared on every clock.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BE_W   = WORD_W / 8;
  localparam int unsigned SLOT_W = 3;
  localparam int unsigned CODE_W = 6;
  localparam int unsigned LVL_W  = 3;
  localparam int unsigned SRC_PER_WORD = 4;

  localparam logic [SLOT_W-1:0] SLOT_STATUS = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_THRESH = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_LVL0   = 3'd4;

  localparam logic [CODE_W-1:0] SRC_CODE_BASE = 6'd16;
  localparam logic [CODE_W-1:0] BYP_CODE      = 6'd32;
  localparam logic [WORD_W-1:0] STATUS_DEFAULT = 32'h0000_FFFF;
endpackage

// File: rtl/irc_edge.sv
module irc_edge #(
  parameter int unsigned W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= line_i;
  end

  assign rise_o = line_i & ~prev_q;
endmodule

// File: rtl/irc_regbank.sv
module irc_regbank
  import irc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          srst,
  input  logic                          wr,
  input  logic [SLOT_W-1:0]             slot,
  input  logic [BE_W-1:0]               be,
  input  logic [WORD_W-1:0]             wdata,
  input  logic [NUM_SRC-1:0]            rise,
  output logic [WORD_W-1:0]             rdata,
  output logic [WORD_W-1:0]             thresh_o,
  output logic [NUM_SRC-1:0][LVL_W-1:0] level_o
);
  localparam int unsigned NLW = NUM_SRC / SRC_PER_WORD;
  localparam int unsigned LANE_W = WORD_W / SRC_PER_WORD;

  logic [WORD_W-1:0]          status_q, thresh_q;
  logic [NLW-1:0][WORD_W-1:0] lvl_q;
  logic [WORD_W-1:0]          status_wr, clr_mask;

  function automatic logic [WORD_W-1:0] merge_lanes(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] new_w,
    input logic [BE_W-1:0]   en);
    logic [WORD_W-1:0] res;
    res = old_w;
    for (int b = 0; b < int'(BE_W); b++)
      if (en[b]) res[b*8 +: 8] = new_w[b*8 +: 8];
    return res;
  endfunction

  assign clr_mask  = {{(WORD_W-NUM_SRC){1'b0}}, rise};
  assign status_wr = (wr && slot == SLOT_STATUS) ? merge_lanes(status_q, wdata, be) : status_q;

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      status_q <= STATUS_DEFAULT;
      thresh_q <= '0;
    end else begin
      status_q <= status_wr & ~clr_mask;
      if (wr && slot == SLOT_THRESH) thresh_q <= merge_lanes(thresh_q, wdata, be);
    end
  end

  for (genvar r = 0; r < int'(NLW); r++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst || srst) lvl_q[r] <= '0;
      else if (wr && slot == SLOT_LVL0 + SLOT_W'(r)) lvl_q[r] <= merge_lanes(lvl_q[r], wdata, be);
    end
  end

  for (genvar s = 0; s < int'(NUM_SRC); s++) begin : g_field
    assign level_o[s] = lvl_q[s / SRC_PER_WORD][(s % SRC_PER_WORD) * LANE_W +: LVL_W];
  end

  assign thresh_o = thresh_q;

  always_comb begin
    rdata = '0;
    if (slot == SLOT_STATUS) rdata = status_q;
    if (slot == SLOT_THRESH) rdata = thresh_q;
    for (int r = 0; r < int'(NLW); r++)
      if (slot == SLOT_LVL0 + SLOT_W'(r)) rdata = lvl_q[r];
  end

  // R4 / R9: an edge leaves its status bit at 0 even under a status write
  assert_edge_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (!srst && rise != '0) |=> ((status_q[NUM_SRC-1:0] & $past(rise)) == '0));

  // R10: soft restore yields the default register image
  assert_soft_default_R10: assert property (@(posedge clk) disable iff (rst)
    srst |=> (status_q == STATUS_DEFAULT && thresh_q == '0));
endmodule

// File: rtl/irc_arb.sv
module irc_arb
  import irc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               srst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               byp_req_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [CODE_W-1:0]  code_o
);
  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] pend_q, pop_vec;
  logic               byp_q, out_v_q, take, pick_hit;
  logic [IDX_W-1:0]   pick_idx;
  logic [CODE_W-1:0]  out_code_q, pick_code;

  always_comb begin
    pick_hit = 1'b0;
    pick_idx = '0;
    for (int i = int'(NUM_SRC) - 1; i >= 0; i--)
      if (pend_q[i]) begin
        pick_hit = 1'b1;
        pick_idx = IDX_W'(i);
      end
  end

  assign take      = !out_v_q || ready_i;
  assign pick_code = byp_q ? BYP_CODE : SRC_CODE_BASE + CODE_W'(pick_idx);
  assign pop_vec   = (take && !byp_q && pick_hit) ? (NUM_SRC'(1) << pick_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      pend_q     <= '0;
      byp_q      <= 1'b0;
      out_v_q    <= 1'b0;
      out_code_q <= '0;
    end else begin
      pend_q <= (pend_q & ~pop_vec) | req_i;
      byp_q  <= (byp_q && !take) || byp_req_i;
      if (take) begin
        out_v_q    <= byp_q || pick_hit;
        out_code_q <= pick_code;
      end
    end
  end

  assign valid_o = out_v_q;
  assign code_o  = out_code_q;

  // R7: a stalled entry holds its code
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_v_q && !ready_i && !srst) |=> (out_v_q && $stable(out_code_q)));

  // R6: presented codes lie in the defined range
  assert_code_range_R6: assert property (@(posedge clk) disable iff (rst)
    out_v_q |-> (out_code_q >= SRC_CODE_BASE && out_code_q <= BYP_CODE));

  // R8: a queued bypass is the next entry presented
  assert_byp_first_R8: assert property (@(posedge clk) disable iff (rst)
    (byp_q && take && !srst) |=> (out_v_q && out_code_q == BYP_CODE));

  // R7: nothing appears when nothing is queued
  assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!out_v_q && pend_q == '0 && !byp_q) |=> !out_v_q);
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import irc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                soft_rst,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                byp_i,
  input  logic                bus_wr,
  input  logic [SLOT_W-1:0]   bus_addr,
  input  logic [BE_W-1:0]     bus_be,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic                irq_valid,
  input  logic                irq_ready,
  output logic [CODE_W-1:0]   irq_code
);
  logic [NUM_SRC:0]              rise_all;
  logic [NUM_SRC-1:0]            src_rise, qual;
  logic [WORD_W-1:0]             thresh;
  logic [NUM_SRC-1:0][LVL_W-1:0] level;

  irc_edge #(.W(NUM_SRC + 1)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .line_i ({byp_i, src_i}),
    .rise_o (rise_all)
  );

  assign src_rise = rise_all[NUM_SRC-1:0];

  irc_regbank #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .srst     (soft_rst),
    .wr       (bus_wr),
    .slot     (bus_addr),
    .be       (bus_be),
    .wdata    (bus_wdata),
    .rise     (src_rise),
    .rdata    (bus_rdata),
    .thresh_o (thresh),
    .level_o  (level)
  );

  for (genvar s = 0; s < int'(NUM_SRC); s++) begin : g_qual
    assign qual[s] = src_rise[s] && ({{(WORD_W-LVL_W){1'b0}}, level[s]} > thresh);
  end

  irc_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .srst      (soft_rst),
    .req_i     (qual),
    .byp_req_i (rise_all[NUM_SRC]),
    .ready_i   (irq_ready),
    .valid_o   (irq_valid),
    .code_o    (irq_code)
  );
endmodule

// File: tb/edge_irq_ctrl_test.sv
`timescale 1ns/1ps
module edge_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1, soft_rst = 1'b0;
  logic [15:0] src_i = '0;
  logic        byp_i = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [5:0]  irq_code;

  int total = 0, bad = 0, evcnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  edge_irq_ctrl uut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .src_i(src_i), .byp_i(byp_i),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_code(irq_code)
  );

  // reference model
  logic [16:0] m_prev;
  logic [31:0] m_status, m_mask;
  logic [31:0] m_lvl [4];
  logic [15:0] m_pend;
  logic        m_byp, m_ov;
  logic [5:0]  m_oc;

  function automatic logic [31:0] lanes(input logic [31:0] o, input logic [31:0] n, input logic [3:0] e);
    logic [31:0] r;
    r = o;
    for (int b = 0; b < 4; b++) if (e[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return m_status;
      3'd1: return m_mask;
      3'd4, 3'd5, 3'd6, 3'd7: return m_lvl[a - 3'd4];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [16:0] cur, rs;
    logic [15:0] q;
    logic        found;
    longint      lv;
    cur = {byp_i, src_i};
    if (rst || soft_rst) begin
      m_status = 32'h0000FFFF; m_mask = 0;
      for (int r = 0; r < 4; r++) m_lvl[r] = 0;
      m_pend = 0; m_byp = 0; m_ov = 0; m_oc = 0;
      m_prev = rst ? 17'h0 : cur;
    end else begin
      rs = cur & ~m_prev;
      q = 0;
      for (int s = 0; s < 16; s++) begin
        lv = longint'((m_lvl[s/4] >> ((s%4)*8)) & 32'h7);
        if (rs[s] && lv > longint'(m_mask)) q[s] = 1'b1;
      end
      if (!m_ov || irq_ready) begin
        if (m_byp) begin m_ov = 1; m_oc = 6'd32; m_byp = 0; end
        else begin
          found = 0;
          for (int s = 0; s < 16; s++)
            if (!found && m_pend[s]) begin found = 1; m_pend[s] = 0; m_oc = 6'(16 + s); end
          m_ov = found;
        end
      end
      m_pend = m_pend | q;
      m_byp  = m_byp | rs[16];
      if (bus_wr) begin
        case (bus_addr)
          3'd0: m_status = lanes(m_status, bus_wdata, bus_be);
          3'd1: m_mask   = lanes(m_mask, bus_wdata, bus_be);
          3'd4, 3'd5, 3'd6, 3'd7: m_lvl[bus_addr - 3'd4] = lanes(m_lvl[bus_addr - 3'd4], bus_wdata, bus_be);
          default: ;
        endcase
      end
      m_status = m_status & ~{16'h0, rs[15:0]};
      m_prev = cur;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check("R7 valid", 32'(irq_valid), 32'(m_ov));
    if (m_ov) check("R8 code", 32'(irq_code), 32'(m_oc));
    check("R2 rdata", bus_rdata, mread(bus_addr));
    if (irq_valid && irq_ready) evcnt++;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wreg(input logic [2:0] a, input logic [3:0] e, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_be = e; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic rdchk(input string req, input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a;
    tick();
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse(input int i);
    if (i == 16) byp_i = 1; else src_i[i] = 1;
    tick();
    if (i == 16) byp_i = 0; else src_i[i] = 0;
  endtask

  initial begin
    ticks(3);
    rst = 0;
    tick();
    // R1 reset image
    check("R1 valid", 32'(irq_valid), 32'h0);
    rdchk("R1 status", 3'd0, 32'h0000FFFF);
    rdchk("R1 thresh", 3'd1, 32'h0);
    for (int r = 4; r < 8; r++) rdchk("R1 level", 3'(r), 32'h0);

    // R3 byte lanes, R2 unmapped slots
    wreg(3'd1, 4'b0101, 32'hAABBCCDD);
    rdchk("R3 lanes", 3'd1, 32'h00BB00DD);
    wreg(3'd2, 4'hF, 32'h12345678);
    rdchk("R2 unmapped 2", 3'd2, 32'h0);
    rdchk("R2 unmapped 3", 3'd3, 32'h0);

    // R5 threshold compare, R4 status clear, R6 source code
    wreg(3'd4, 4'hF, 32'h04030201);
    wreg(3'd1, 4'hF, 32'd2);
    wreg(3'd0, 4'hF, 32'h0000FFFF);
    irq_ready = 0;
    pulse(0); ticks(3);
    check("R5 below threshold", 32'(irq_valid), 32'h0);
    rdchk("R4 status bit0", 3'd0, 32'h0000FFFE);
    pulse(3); ticks(3);
    check("R5 above threshold", 32'(irq_valid), 32'h1);
    check("R6 code 19", 32'(irq_code), 32'd19);
    rdchk("R4 status bits", 3'd0, 32'h0000FFF6);
    irq_ready = 1; ticks(2);
    check("R7 drained", 32'(irq_valid), 32'h0);

    // R5 field position of source 13 and strict compare
    wreg(3'd7, 4'b0010, 32'h0000FD00);
    wreg(3'd1, 4'hF, 32'd5);
    pulse(13); ticks(3);
    check("R5 equal not forwarded", 32'(irq_valid), 32'h0);
    wreg(3'd1, 4'hF, 32'd4);
    irq_ready = 0;
    pulse(13); ticks(3);
    check("R6 code 29", 32'(irq_code), 32'd29);
    irq_ready = 1; ticks(2);

    // R6 bypass leaves status untouched
    wreg(3'd0, 4'hF, 32'h0000FFFF);
    wreg(3'd1, 4'hF, 32'hFFFFFFFF);
    irq_ready = 0;
    pulse(16); ticks(3);
    check("R6 bypass valid", 32'(irq_valid), 32'h1);
    check("R6 bypass code", 32'(irq_code), 32'd32);
    rdchk("R6 status kept", 3'd0, 32'h0000FFFF);
    irq_ready = 1; ticks(2);

    // R8 ordering of simultaneous edges under stall
    for (int r = 4; r < 8; r++) wreg(3'(r), 4'hF, 32'h07070707);
    wreg(3'd1, 4'hF, 32'd0);
    irq_ready = 0;
    src_i[2] = 1; src_i[5] = 1; src_i[9] = 1; byp_i = 1;
    tick();
    src_i = '0; byp_i = 0;
    ticks(4);
    check("R8 first bypass", 32'(irq_code), 32'd32);
    check("R7 held valid", 32'(irq_valid), 32'h1);
    irq_ready = 1; tick();
    check("R8 second", 32'(irq_code), 32'd18);
    tick();
    check("R8 third", 32'(irq_code), 32'd21);
    tick();
    check("R8 fourth", 32'(irq_code), 32'd25);
    tick();
    check("R8 empty", 32'(irq_valid), 32'h0);

    // R11 merge of repeated edges while queued
    irq_ready = 0;
    pulse(1); ticks(2);
    pulse(4); tick();
    pulse(4); ticks(2);
    check("R11 presented", 32'(irq_code), 32'd17);
    irq_ready = 1; tick();
    check("R11 merged", 32'(irq_code), 32'd20);
    tick();
    check("R11 single", 32'(irq_valid), 32'h0);

    // R4 held line gives one event
    wreg(3'd0, 4'hF, 32'h0000FFFF);
    evcnt = 0;
    src_i[6] = 1; ticks(8);
    check("R4 one event", 32'(evcnt), 32'd1);
    wreg(3'd0, 4'hF, 32'h0000FFFF);
    rdchk("R4 no retrigger", 3'd0, 32'h0000FFFF);
    src_i[6] = 0; ticks(2);

    // R9 write and edge in the same cycle
    bus_wr = 1; bus_addr = 3'd0; bus_be = 4'b0011; bus_wdata = 32'h0000FFFF;
    src_i[7] = 1;
    tick();
    bus_wr = 0; src_i[7] = 0;
    rdchk("R9 edge wins", 3'd0, 32'h0000FF7F);
    ticks(3);

    // R10 soft restore with queued work and a same-cycle edge
    wreg(3'd1, 4'hF, 32'd3);
    irq_ready = 0;
    pulse(9); ticks(2);
    check("R10 setup", 32'(irq_valid), 32'h1);
    soft_rst = 1; src_i[2] = 1;
    tick();
    soft_rst = 0; src_i[2] = 0;
    ticks(3);
    check("R10 port empty", 32'(irq_valid), 32'h0);
    rdchk("R10 thresh", 3'd1, 32'h0);
    rdchk("R10 status", 3'd0, 32'h0000FFFF);
    rdchk("R10 level", 3'd4, 32'h0);
    irq_ready = 1; ticks(4);
    check("R10 nothing late", 32'(irq_valid), 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule